// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts video scanlines downward and raises an interrupt to the CPU when a countdown expires. A separate circuit, not part of this block, supplies a one-cycle tick for each scanline. The CPU programs the block by writing to mapped addresses. Those writes load a reload value, request that the counter restart from that value, turn the interrupt on, or turn it off while acknowledging a pending request.

On every tick the counter does one of two things. If it is at zero, or a restart was requested, it loads the reload value. Otherwise it steps down by one. An interrupt is raised only when a decrement moves a nonzero count to zero while the interrupt is on. A reload is never a cause, even when it lands on zero. The lowest bit of the reload value always reads as zero, so every countdown has an even length. The interrupt line is a level: it stays high until the CPU acknowledges it.

Software sets the line spacing with a latch write and a restart request. After a restart with reload value L (L nonzero), the interrupt appears after tick number L+1. Writing a reload value of zero makes the block reload to zero on every tick, and it never fires.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write whose address ANDed with 0xE001 equals 0xC000 stores the data as the reload value, with bit 0 forced to 0. Writing 0x03 therefore behaves exactly like writing 0x02.
- R2: A write whose masked address equals 0xC001 sets a restart request. The next tick loads the count from the reload value, whatever the current count, and clears the request.
- R3: A tick with no restart request reloads a zero count and decrements a nonzero count by one. After a restart with reload value L > 0, the interrupt appears on tick L+1.
- R4: `irq` rises only after a tick whose decrement takes the count from nonzero to zero. A reload never raises it, including a restart onto a reload value of 0 from a nonzero count, and repeated reloads of 0.
- R5: Once high, `irq` stays high across further ticks until a write whose masked address equals 0xE000. That write lowers `irq` and turns the interrupt off.
- R6: A write whose masked address equals 0xE001 turns the interrupt on. A count that reaches zero while the interrupt is off raises nothing, either then or when the interrupt is turned on later.
- R7: After reset, `irq` is low, the interrupt is off, and both the count and the reload value are zero. With no further programming, no tick raises `irq`.
- R8: Only address bits 15..13 and bit 0 are decoded, so aliases such as 0xDFFE, 0xC7FF, 0xFFFF and 0xFFFE act like the base addresses. Writes whose masked address is 0x8000, 0x8001, 0xA000 or 0xA001, or whose address is below 0x8000, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | Single-cycle pulse, once per scanline |
| irq | output | 1 | Active-high interrupt request, held until acknowledged |

## Verification
The hardest case to reach from the ports is a reload that lands on zero from a nonzero count, because the count itself cannot be seen. The stimulus first starts a countdown from 4 and lets two ticks pass, so the count is known to be 3. It then writes a reload value of 0 and requests a restart, and checks that neither that tick nor the many zero-reloads that follow raise `irq`. A second hard case is a count that expires while the interrupt is off. The bench lets the count expire with the interrupt off, turns the interrupt on, and checks that `irq` stays low until the next real expiry.

// File: rtl/irq_cnt_pkg.sv
package irq_cnt_pkg;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_LATCH  = 3'd1,
    CMD_RELOAD = 3'd2,
    CMD_DIS    = 3'd3,
    CMD_EN     = 3'd4
  } irq_cmd_e;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_cnt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output irq_cmd_e          cmd,
  output logic [CNT_W-1:0]  latch_val
);

  localparam logic [ADDR_W-1:0] DEC_MASK  = ADDR_W'(16'hE001);
  localparam logic [ADDR_W-1:0] A_LATCH   = ADDR_W'(16'hC000);
  localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(16'hC001);
  localparam logic [ADDR_W-1:0] A_DIS     = ADDR_W'(16'hE000);
  localparam logic [ADDR_W-1:0] A_EN      = ADDR_W'(16'hE001);
  localparam logic [CNT_W-1:0]  EVEN_MASK = ~CNT_W'(1);

  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked    = wr_addr & DEC_MASK;
    latch_val = wr_data & EVEN_MASK;
    cmd       = CMD_NONE;
    if (wr_en) begin
      case (masked)
        A_LATCH:  cmd = CMD_LATCH;
        A_RELOAD: cmd = CMD_RELOAD;
        A_DIS:    cmd = CMD_DIS;
        A_EN:     cmd = CMD_EN;
        default:  cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_down_counter.sv
module irq_down_counter
  import irq_cnt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irq_cmd_e         cmd,
  input  logic [CNT_W-1:0] latch_val,
  input  logic             tick,
  output logic             zero_hit
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] latch_q, latch_d;
  logic             pend_q, pend_d;
  logic             cnt_ce, latch_ce, pend_ce;
  logic             do_load;

  always_comb begin
    do_load  = (cnt_q == ZERO) || pend_q;
    cnt_ce   = tick;
    cnt_d    = do_load ? latch_q : (cnt_q - ONE);
    latch_ce = (cmd == CMD_LATCH);
    latch_d  = latch_val;
    pend_ce  = tick || (cmd == CMD_RELOAD);
    pend_d   = (cmd == CMD_RELOAD);
    zero_hit = tick && !do_load && (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= ZERO;
      latch_q <= ZERO;
      pend_q  <= 1'b0;
    end else begin
      if (cnt_ce)   cnt_q   <= cnt_d;
      if (latch_ce) latch_q <= latch_d;
      if (pend_ce)  pend_q  <= pend_d;
    end
  end

  // R1
  latch_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LATCH) |=> (latch_q[0] == 1'b0) && (latch_q[CNT_W-1:1] == $past(latch_val[CNT_W-1:1])));

  // R2
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q) |=> (cnt_q == $past(latch_q)));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irq_cnt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_cmd_e cmd,
  input  logic     zero_hit,
  output logic     irq
);

  logic en_q, en_d, en_ce;
  logic irq_q, irq_d, irq_ce;

  always_comb begin
    en_ce  = (cmd == CMD_EN) || (cmd == CMD_DIS);
    en_d   = (cmd == CMD_EN);
    irq_ce = (cmd == CMD_DIS) || (zero_hit && en_q);
    irq_d  = (cmd != CMD_DIS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (irq_ce) irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(zero_hit));

  // R6
  rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(en_q));

  // R5
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && cmd != CMD_DIS) |=> irq_q);

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DIS) |=> (!irq_q && !en_q));

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import irq_cnt_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              line_tick,
  output logic              irq
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  irq_cmd_e               cmd;
  logic [CNT_W-1:0]       latch_val;
  logic                   zero_hit;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  irq_wr_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmd       (cmd),
    .latch_val (latch_val)
  );

  irq_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd       (cmd),
    .latch_val (latch_val),
    .tick      (line_tick),
    .zero_hit  (zero_hit)
  );

  irq_line_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd      (cmd),
    .zero_hit (zero_hit),
    .irq      (irq)
  );

endmodule

// File: tb/tb_scanline_irq_counter.sv
module tb_scanline_irq_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_tick = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scanline_irq_counter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_tick(line_tick), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic one_tick();
    @(negedge clk);
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
  endtask

  // returns number of the tick after which irq was first high, -1 if none
  task automatic ticks_to_irq(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      one_tick();
      if (irq && n < 0) n = i;
      if (n >= 0) break;
    end
  endtask

  task automatic t_reset();
    int n;
    check(irq == 1'b0, "R7 irq low after reset", irq, 0);
    cpu_wr(16'hE001, 8'h00);
    check(irq == 1'b0, "R7 enable alone raises nothing", irq, 0);
    ticks_to_irq(20, n);
    check(n == -1, "R7 reset count and reload value are zero", n, -1);
  endtask

  task automatic t_latch2();
    int n;
    cpu_wr(16'hC000, 8'h02);
    cpu_wr(16'hC001, 8'h00);
    cpu_wr(16'hE001, 8'h00);
    ticks_to_irq(10, n);
    check(n == 3, "R3 reload 2 fires on tick 3", n, 3);
    for (int i = 0; i < 5; i++) one_tick();
    check(irq == 1'b1, "R5 irq held across ticks", irq, 1);
    cpu_wr(16'hE000, 8'h00);
    check(irq == 1'b0, "R5 ack lowers irq", irq, 0);
    ticks_to_irq(8, n);
    check(n == -1, "R5 ack also disables", n, -1);
  endtask

  task automatic t_odd_latch();
    int n;
    cpu_wr(16'hC000, 8'h03);
    cpu_wr(16'hC001, 8'h00);
    cpu_wr(16'hE001, 8'h00);
    ticks_to_irq(10, n);
    check(n == 3, "R1 bit0 cleared, 0x03 acts as 2", n, 3);
    cpu_wr(16'hE000, 8'h00);
  endtask

  task automatic t_latch_fe();
    int n;
    cpu_wr(16'hC000, 8'hFE);
    cpu_wr(16'hC001, 8'h00);
    cpu_wr(16'hE001, 8'h00);
    ticks_to_irq(300, n);
    check(n == 255, "R2 restart from 0xFE fires on tick 255", n, 255);
    cpu_wr(16'hE000, 8'h00);
  endtask

  task automatic t_latch0();
    int n;
    cpu_wr(16'hC000, 8'h04);
    cpu_wr(16'hC001, 8'h00);
    cpu_wr(16'hE001, 8'h00);
    one_tick();
    one_tick();
    cpu_wr(16'hC000, 8'h00);
    cpu_wr(16'hC001, 8'h00);
    one_tick();
    check(irq == 1'b0, "R4 restart onto zero from nonzero does not fire", irq, 0);
    ticks_to_irq(600, n);
    check(n == -1, "R4 reload value 0 never fires", n, -1);
    cpu_wr(16'hE000, 8'h00);
  endtask

  task automatic t_disabled();
    int n;
    cpu_wr(16'hC000, 8'h02);
    cpu_wr(16'hC001, 8'h00);
    one_tick(); one_tick(); one_tick();
    check(irq == 1'b0, "R6 expiry while off raises nothing", irq, 0);
    cpu_wr(16'hE001, 8'h00);
    @(negedge clk);
    check(irq == 1'b0, "R6 enabling is not retroactive", irq, 0);
    ticks_to_irq(10, n);
    check(n == 3, "R6 next expiry after enable fires", n, 3);
    cpu_wr(16'hE000, 8'h00);
  endtask

  task automatic t_decode();
    int n;
    cpu_wr(16'hDFFE, 8'h04);
    cpu_wr(16'h8000, 8'h10);
    cpu_wr(16'h8001, 8'h12);
    cpu_wr(16'hA000, 8'h20);
    cpu_wr(16'hA001, 8'h30);
    cpu_wr(16'h4000, 8'h40);
    cpu_wr(16'h6001, 8'h50);
    cpu_wr(16'hC7FF, 8'h00);
    cpu_wr(16'hFFFF, 8'h00);
    ticks_to_irq(10, n);
    check(n == 5, "R8 aliases decode, other writes ignored", n, 5);
    cpu_wr(16'hFFFE, 8'h00);
    check(irq == 1'b0, "R8 ack alias lowers irq", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch2();
    t_odd_latch();
    t_latch_fe();
    t_latch0();
    t_disabled();
    t_decode();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule